// File: doc/BRIEF.md
# Extended Integer Divide Unit

This unit performs three integer divide operations for a processor datapath, one quotient bit per clock. The caller presents an operation select, the three 16-bit register values D, X and Y, and the current N, Z, V and C flags. It then pulses `start`. The unit returns the new D, X and Y values and the new flags, and marks them with a one-cycle `done` pulse.

The three operations are:
- a signed 16-by-16 divide of D by X;
- an unsigned 32-by-16 divide of Y:D (Y is the high half) by X;
- a signed 32-by-16 divide of Y:D by X.

The signed forms work on magnitudes and fix the signs of the results afterwards. Division truncates toward zero, and the remainder takes the sign of the dividend. A zero divisor is reported through C alone: every register and the other flags are returned unchanged.

Every divide takes the same fixed time, whatever the operands, so the caller can plan around it. The results stay on the outputs until the next divide completes.

Top module: `xdiv_unit`

## Requirements
- R1: A `start` seen while `busy` is low is accepted, and `busy` is high after that edge. A `start` seen while `busy` is high is ignored: the operands given with it never affect any output.
- R2: `done` is high for exactly one cycle, 33 clock edges after the edge that accepted `start`. `busy` falls on that same edge.
- R3: When the divisor X is zero, C (bit 0 of the flags) is 1. D, X, Y and flag bits 3..1 are returned exactly as they were given at start.
- R4: With a nonzero divisor, C is 0. Z (bit 2) is 1 exactly when the quotient is zero. N (bit 3) equals bit 15 of the 16-bit quotient written.
- R5: For `op` = 0 (signed 16-by-16), the quotient goes to X and the remainder to D, and Y is unchanged. The quotient truncates toward zero, and the remainder has the sign of the dividend.
- R6: For `op` = 0, −32768 divided by −1 sets V (bit 1) and writes 0x8000 to X. No other 16-by-16 operands set V.
- R7: For `op` = 1 (unsigned 32-by-16 of Y:D by X), the quotient goes to Y and the remainder to D, and X is unchanged. V is set when the quotient exceeds 65535, and the low 16 quotient bits are still written.
- R8: For `op` = 2 (signed 32-by-16 of Y:D by X), the quotient goes to Y and the remainder to D. V is set when the quotient lies outside −32768..32767, and its low 16 bits are still written.
- R9: `op` = 3 behaves exactly like `op` = 1.
- R10: After reset, `busy` and `done` are 0, and D, X, Y and the flags outputs are all 0.
- R11: The data and flag outputs change only on the edge that raises `done`, and hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a divide; accepted only while idle |
| op | input | 2 | 0 signed 16/16, 1 unsigned 32/16, 2 signed 32/16, 3 as 1 |
| d_in | input | 16 | D register value |
| x_in | input | 16 | X register value (divisor) |
| y_in | input | 16 | Y register value (dividend high half) |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| d_out | output | 16 | New D value |
| x_out | output | 16 | New X value |
| y_out | output | 16 | New Y value |
| flags_out | output | 4 | New flags {N,Z,V,C} |

## Verification
The signed 16-by-16 divide is run with all four sign combinations of dividend and divisor, so an error in the quotient sign correction shows up apart from an error in the remainder sign correction. Further runs cover a zero quotient, a zero divisor and the single overflowing pair.

The 32-by-16 forms are run with quotients that fit and quotients that do not. The unsigned case and the signed case are given the same bit patterns, which exposes a mix-up of the magnitude step. The signed overflow cases sit on both the positive and the negative edge of the range.

One run presents a second start with different operands while busy, to show that it leaves no trace. Op 3 is run with the same operands as op 1, to show the two give the same result.

// File: rtl/xdiv_unit.sv
module xdiv_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [3:0]   flags_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] d_out,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic [3:0]   flags_out
);
  localparam int W2 = 2 * W;
  localparam int CW = $clog2(W2 + 1);
  localparam logic [CW-1:0] LAST = CW'(W2);
  localparam logic [W2-1:0] SMAX = (W2'(1) << (W - 1)) - W2'(1);
  localparam logic [W2-1:0] SMIN_MAG = W2'(1) << (W - 1);

  logic [1:0]    op_r;
  logic [W-1:0]  d_r, x_r, y_r;
  logic [3:0]    f_r;
  logic          neg_dd, neg_dv;
  logic [W-1:0]  dvs, rem;
  logic [W2-1:0] quo;
  logic [CW-1:0] cnt;

  wire in_signed = (op == 2'd0) || (op == 2'd2);
  wire [W2-1:0] dvd_in = (op == 2'd0) ? {{W{d_in[W-1]}}, d_in} : {y_in, d_in};
  wire in_neg_dd = in_signed && dvd_in[W2-1];
  wire in_neg_dv = in_signed && x_in[W-1];

  wire [W:0] shifted = {rem, quo[W2-1]};
  wire       fits = shifted >= {1'b0, dvs};
  wire [W:0] diff = shifted - {1'b0, dvs};

  wire r_signed = (op_r == 2'd0) || (op_r == 2'd2);
  wire neg_q = r_signed && (neg_dd ^ neg_dv);
  wire [W2-1:0] q_full = neg_q ? (~quo + W2'(1)) : quo;
  wire [W-1:0] rem_fix = (r_signed && neg_dd) ? (~rem + W'(1)) : rem;
  wire v_res = r_signed ? (neg_q ? (quo > SMIN_MAG) : (quo > SMAX)) : (|quo[W2-1:W]);
  wire z_res = (quo == '0);
  wire [W-1:0] q16 = q_full[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt <= '0;
      op_r <= '0;
      d_r <= '0;
      x_r <= '0;
      y_r <= '0;
      f_r <= '0;
      neg_dd <= 1'b0;
      neg_dv <= 1'b0;
      dvs <= '0;
      rem <= '0;
      quo <= '0;
      d_out <= '0;
      x_out <= '0;
      y_out <= '0;
      flags_out <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt <= '0;
          op_r <= op;
          d_r <= d_in;
          x_r <= x_in;
          y_r <= y_in;
          f_r <= flags_in;
          neg_dd <= in_neg_dd;
          neg_dv <= in_neg_dv;
          dvs <= in_neg_dv ? (~x_in + W'(1)) : x_in;
          quo <= in_neg_dd ? (~dvd_in + W2'(1)) : dvd_in;
          rem <= '0;
        end
      end else if (cnt != LAST) begin
        cnt <= cnt + CW'(1);
        rem <= fits ? diff[W-1:0] : shifted[W-1:0];
        quo <= {quo[W2-2:0], fits};
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        if (x_r == '0) begin
          d_out <= d_r;
          x_out <= x_r;
          y_out <= y_r;
          flags_out <= {f_r[3:1], 1'b1};
        end else begin
          d_out <= rem_fix;
          x_out <= (op_r == 2'd0) ? q16 : x_r;
          y_out <= (op_r == 2'd0) ? y_r : q16;
          flags_out <= {q16[W-1], z_res, v_res, 1'b0};
        end
      end
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_run_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> (busy && !done));

  p_zero_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && x_r == '0) |-> (flags_out[0] && d_out == d_r && y_out == y_r && x_out == '0));

  p_nonzero_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && x_r != '0) |-> (!flags_out[0] && flags_out[3] == (op_r == 2'd0 ? x_out[W-1] : y_out[W-1])));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(rst_n)) |-> ($stable(d_out) && $stable(x_out) && $stable(y_out) && $stable(flags_out)));
endmodule

// File: tb/sim_xdiv_unit.sv
module sim_xdiv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = '0;
  logic [15:0] d_in = '0, x_in = '0, y_in = '0;
  logic [3:0] flags_in = '0;
  logic busy, done;
  logic [15:0] d_out, x_out, y_out;
  logic [3:0] flags_out;

  xdiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .d_in(d_in), .x_in(x_in), .y_in(y_in), .flags_in(flags_in),
    .busy(busy), .done(done), .d_out(d_out), .x_out(x_out),
    .y_out(y_out), .flags_out(flags_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_tag = "R10";

  logic m_busy = 0, m_done = 0;
  int left = 0;
  logic [51:0] pend = '0;
  logic [51:0] shown = '0;

  function automatic logic [51:0] ref_div(input logic [1:0] o, input logic [15:0] dd, xx, yy,
                                          input logic [3:0] ff);
    longint a, b, q, r;
    logic v;
    logic [15:0] q16, r16;
    if (xx == 16'd0) return {dd, xx, yy, ff[3:1], 1'b1};
    if (o == 2'd0) begin
      a = longint'($signed(dd));
      b = longint'($signed(xx));
    end else if (o == 2'd2) begin
      a = longint'($signed({yy, dd}));
      b = longint'($signed(xx));
    end else begin
      a = longint'({32'd0, yy, dd});
      b = longint'({48'd0, xx});
    end
    q = a / b;
    r = a % b;
    if (o == 2'd0 || o == 2'd2) v = (q > 32767) || (q < -32768);
    else v = (q > 65535);
    q16 = q[15:0];
    r16 = r[15:0];
    if (o == 2'd0) return {r16, q16, yy, q16[15], (q == 0), v, 1'b0};
    return {r16, xx, q16, q16[15], (q == 0), v, 1'b0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; left = 0; shown = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        left = left - 1;
        if (left == 0) begin
          m_busy = 0; m_done = 1; shown = pend;
        end
      end else if (start) begin
        m_busy = 1;
        left = LAT;
        pend = ref_div(op, d_in, x_in, y_in, flags_in);
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(rst_n ? "R2" : "R10", "busy", {15'd0, busy}, {15'd0, m_busy});
    chk(rst_n ? "R2" : "R10", "done", {15'd0, done}, {15'd0, m_done});
    chk(rst_n ? cur_tag : "R10", "d_out", d_out, shown[51:36]);
    chk(rst_n ? cur_tag : "R10", "x_out", x_out, shown[35:20]);
    chk(rst_n ? cur_tag : "R10", "y_out", y_out, shown[19:4]);
    chk(rst_n ? cur_tag : "R11", "flags", {12'd0, flags_out}, {12'd0, shown[3:0]});
  end

  task automatic run(input logic [1:0] o, input logic [15:0] dd, xx, yy,
                     input logic [3:0] ff, input string tag, input bit poke);
    cur_tag = tag;
    op = o; d_in = dd; x_in = xx; y_in = yy; flags_in = ff;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      op = 2'd0; d_in = 16'h1111; x_in = 16'h0003; y_in = 16'h2222; flags_in = 4'hF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<50000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run(2'd0, 16'd7, 16'd2, 16'hAAAA, 4'h0, "R5", 0);
    run(2'd0, -16'sd7, 16'd2, 16'h5555, 4'h0, "R5", 0);
    run(2'd0, 16'd7, -16'sd2, 16'h0001, 4'h0, "R5", 0);
    run(2'd0, -16'sd7, -16'sd2, 16'h0002, 4'h0, "R5", 0);
    run(2'd0, 16'h8000, 16'hFFFF, 16'h1234, 4'h0, "R6", 0);
    run(2'd0, 16'h8000, 16'h0001, 16'h1234, 4'h0, "R6", 0);
    run(2'd0, 16'd3, 16'd9, 16'h0000, 4'hF, "R4", 0);
    run(2'd0, 16'hBEEF, 16'd0, 16'hCAFE, 4'hA, "R3", 0);
    run(2'd1, 16'h5678, 16'h1234, 16'h1234, 4'h0, "R7", 0);
    run(2'd1, 16'h86A0, 16'd7, 16'h0001, 4'h0, "R7", 0);
    run(2'd1, 16'h0001, 16'd0, 16'h0002, 4'h4, "R3", 0);
    run(2'd3, 16'h5678, 16'h1234, 16'h1234, 4'h0, "R9", 0);
    run(2'd2, 16'h7960, 16'd7, 16'hFFFE, 4'h0, "R8", 0);
    run(2'd2, 16'hFFFF, 16'd1, 16'h7FFF, 4'h0, "R8", 0);
    run(2'd2, 16'h0000, 16'hFFFF, 16'h8000, 4'h0, "R8", 0);
    run(2'd2, 16'h8000, 16'hFFFF, 16'h0000, 4'h0, "R8", 0);
    run(2'd2, 16'h7FFF, 16'hFFFF, 16'hFFFF, 4'h0, "R8", 0);
    run(2'd2, 16'h5678, 16'h1234, 16'h1234, 4'h0, "R8", 0);
    run(2'd1, 16'h0010, 16'h0005, 16'h0000, 4'h0, "R1", 1);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule